// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block merges the interrupt causes of a UART into a single interrupt request line and a read-only identification byte. It samples seven cause indications into registered pending flags: line status error, receive timeout, receive data ready, transmit holding empty, modem status change, special-character match and a flow-control deassertion. Each cause is gated by its enable bit. Only the most urgent enabled cause is encoded in the byte.

Two causes are kept as sticky flags inside the block. The first is the special-character comparator, which compares every byte on its way into the receive FIFO against a programmed match value. The byte is forwarded unchanged in every case. The second is an edge detector on the CTS and RTS levels, which flags a move from active low to inactive high. Transmit-empty is also held inside the block. It is cleared by a load of the holding register, or by a read of the byte while the transmit-empty code is showing. The level causes follow their inputs, one clock late.

Top module: `uart_irq_ident`

## Requirements
- R1: Bit 0 of `iid` is active low. It is 0 when an enabled cause is pending and 1 otherwise. With nothing pending, bits 5:0 read 000001 and `irq` is low.
- R2: An enabled line status error has the highest priority and reads as 000110 in bits 5:0.
- R3: Receive timeout (001100) and receive data ready (000100) share the second level. Timeout is shown when both are pending.
- R4: Transmit holding empty is third (000010). It is set by a `thr_set` pulse and cleared by `thr_load`. It is also cleared by an `id_rd` in a cycle where 000010 is showing. A set in the same cycle as a clear wins.
- R5: A modem status change is fourth and reads as 000000.
- R6: With `spc_en` high, a byte written through `rx_wr`/`rx_byte` that equals `xoff2` sets a sticky flag, reported fifth as 010000, until `spc_clr`. The byte always appears unchanged on `fifo_wr`/`fifo_byte`.
- R7: A low-to-high move on `cts_n` or `rts_n` sets a sticky flag, reported sixth and last as 100000, until `flow_clr`.
- R8: Bits 7:6 of `iid` both equal `fifo_en`.
- R9: Enable bits: `ien[0]` line status, `ien[1]` timeout and data ready, `ien[2]` transmit empty, `ien[3]` modem, `ien[4]` special character, `ien[5]` flow. A disabled cause neither shows in `iid` nor raises `irq`. `irq` is high when any enabled cause is pending.
- R10: Reading `iid` clears no cause other than transmit-empty, and clears that one only when its code is showing.
- R11: The pending flags are registered. A change of a cause input shows in `iid` after the next rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable control bit, mirrored into iid[7:6] |
| ien | input | 6 | Per-cause enables |
| lsr_err | input | 1 | Line status error level |
| rx_tmo | input | 1 | Receive timeout level |
| rx_rdy | input | 1 | Receive data ready level |
| thr_set | input | 1 | Transmit holding became empty (pulse) |
| thr_load | input | 1 | Transmit holding written (pulse) |
| msr_chg | input | 1 | Modem status change level |
| spc_en | input | 1 | Special-character compare enable |
| xoff2 | input | DW | Match value for the comparator |
| rx_wr | input | 1 | Receive byte write strobe |
| rx_byte | input | DW | Received byte |
| spc_clr | input | 1 | Clears the special-character flag |
| cts_n | input | 1 | CTS level, active low |
| rts_n | input | 1 | RTS level, active low |
| flow_clr | input | 1 | Clears the flow-deassertion flag |
| id_rd | input | 1 | Read strobe of the identification byte |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_byte | output | DW | Byte to the receive FIFO |

## Verification
The pending state is not visible except through `iid` and `irq`. A flag that was set or cleared wrongly therefore shows one clock after the causing edge, either as a wrong code or as a wrong `irq` level. Two cases can stay hidden while a more urgent cause is pending: a lost sticky flag, and a transmit-empty flag cleared by a read of another code. The bench drops the urgent causes after such events so that the lower codes are revealed. A behavioural model is compared against the byte on every cycle, so any divergence is caught within one cycle of its becoming observable.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [5:0]    ien,
  input  logic          lsr_err,
  input  logic          rx_tmo,
  input  logic          rx_rdy,
  input  logic          thr_set,
  input  logic          thr_load,
  input  logic          msr_chg,
  input  logic          spc_en,
  input  logic [DW-1:0] xoff2,
  input  logic          rx_wr,
  input  logic [DW-1:0] rx_byte,
  input  logic          spc_clr,
  input  logic          cts_n,
  input  logic          rts_n,
  input  logic          flow_clr,
  input  logic          id_rd,
  output logic [7:0]    iid,
  output logic          irq,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_byte
);

  localparam logic [5:0] C_LSR  = 6'b000110;
  localparam logic [5:0] C_TMO  = 6'b001100;
  localparam logic [5:0] C_RDY  = 6'b000100;
  localparam logic [5:0] C_THR  = 6'b000010;
  localparam logic [5:0] C_MSR  = 6'b000000;
  localparam logic [5:0] C_SPC  = 6'b010000;
  localparam logic [5:0] C_FLOW = 6'b100000;
  localparam logic [5:0] C_NONE = 6'b000001;

  logic lsr_q, tmo_q, rdy_q, thr_q, msr_q, spc_q, flow_q;
  logic cts_d, rts_d;
  logic [5:0] code;
  logic spc_hit, flow_rise, thr_rd_clr;

  assign spc_hit    = rx_wr && spc_en && (rx_byte == xoff2);
  assign flow_rise  = (cts_n && !cts_d) || (rts_n && !rts_d);
  assign thr_rd_clr = id_rd && (code == C_THR);

  assign fifo_wr   = rx_wr;
  assign fifo_byte = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsr_q <= 1'b0;
      tmo_q <= 1'b0;
      rdy_q <= 1'b0;
      msr_q <= 1'b0;
    end else begin
      lsr_q <= lsr_err;
      tmo_q <= rx_tmo;
      rdy_q <= rx_rdy;
      msr_q <= msr_chg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       thr_q <= 1'b0;
    else if (thr_set)                 thr_q <= 1'b1;
    else if (thr_load || thr_rd_clr)  thr_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        spc_q <= 1'b0;
    else if (spc_hit)  spc_q <= 1'b1;
    else if (spc_clr)  spc_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_q <= 1'b0;
      cts_d  <= 1'b1;
      rts_d  <= 1'b1;
    end else begin
      cts_d <= cts_n;
      rts_d <= rts_n;
      if (flow_rise)     flow_q <= 1'b1;
      else if (flow_clr) flow_q <= 1'b0;
    end
  end

  always_comb begin
    if      (lsr_q  && ien[0]) code = C_LSR;
    else if (tmo_q  && ien[1]) code = C_TMO;
    else if (rdy_q  && ien[1]) code = C_RDY;
    else if (thr_q  && ien[2]) code = C_THR;
    else if (msr_q  && ien[3]) code = C_MSR;
    else if (spc_q  && ien[4]) code = C_SPC;
    else if (flow_q && ien[5]) code = C_FLOW;
    else                       code = C_NONE;
  end

  assign irq = (lsr_q && ien[0]) || ((tmo_q || rdy_q) && ien[1]) || (thr_q && ien[2]) ||
               (msr_q && ien[3]) || (spc_q && ien[4]) || (flow_q && ien[5]);
  assign iid = {fifo_en, fifo_en, code};

  assert_irq_bit0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq != iid[0]);

  assert_lsr_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_q && ien[0]) |-> (iid[5:0] == C_LSR));

  assert_tmo_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lsr_q && ien[0]) && tmo_q && rdy_q && ien[1]) |-> (iid[5:0] == C_TMO));

  assert_thr_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && iid[5:0] == C_THR && !thr_set) |=> !thr_q);

  assert_thr_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q && !thr_load && !(id_rd && iid[5:0] == C_THR)) |=> thr_q);

  assert_spc_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr && spc_en && rx_byte == xoff2) |=> spc_q);

  assert_spc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spc_q && !spc_clr) |=> spc_q);

  assert_flow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_q && !flow_clr) |=> flow_q);

  assert_code_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iid[5], iid[4], iid[3] || iid[2] || iid[1], iid[0]}));

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, lsr_err = 0, rx_tmo = 0, rx_rdy = 0, thr_set = 0, thr_load = 0;
  logic msr_chg = 0, spc_en = 0, rx_wr = 0, spc_clr = 0, cts_n = 1, rts_n = 1, flow_clr = 0, id_rd = 0;
  logic [5:0] ien = 6'h3f;
  logic [DW-1:0] xoff2 = 8'h13, rx_byte = 0;
  logic [7:0] iid;
  logic irq, fifo_wr;
  logic [DW-1:0] fifo_byte;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_lsr, m_tmo, m_rdy, m_thr, m_msr, m_spc, m_flow, m_pc = 1, m_pr = 1;

  uart_irq_ident #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ien(ien), .lsr_err(lsr_err),
    .rx_tmo(rx_tmo), .rx_rdy(rx_rdy), .thr_set(thr_set), .thr_load(thr_load),
    .msr_chg(msr_chg), .spc_en(spc_en), .xoff2(xoff2), .rx_wr(rx_wr), .rx_byte(rx_byte),
    .spc_clr(spc_clr), .cts_n(cts_n), .rts_n(rts_n), .flow_clr(flow_clr), .id_rd(id_rd),
    .iid(iid), .irq(irq), .fifo_wr(fifo_wr), .fifo_byte(fifo_byte));

  always #2.5 clk = ~clk;

  function automatic logic [5:0] m_code();
    if (m_lsr && ien[0]) return 6'b000110;
    if (m_tmo && ien[1]) return 6'b001100;
    if (m_rdy && ien[1]) return 6'b000100;
    if (m_thr && ien[2]) return 6'b000010;
    if (m_msr && ien[3]) return 6'b000000;
    if (m_spc && ien[4]) return 6'b010000;
    if (m_flow && ien[5]) return 6'b100000;
    return 6'b000001;
  endfunction

  function automatic string req_of(logic [5:0] c);
    case (c)
      6'b000110: return "R2";
      6'b001100, 6'b000100: return "R3";
      6'b000010: return "R4";
      6'b000000: return "R5";
      6'b010000: return "R6";
      6'b100000: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_lsr, m_tmo, m_rdy, m_thr, m_msr, m_spc, m_flow} = '0;
      m_pc = 1; m_pr = 1;
    end else begin
      logic [5:0] cur;
      cur = m_code();
      m_lsr = lsr_err; m_tmo = rx_tmo; m_rdy = rx_rdy; m_msr = msr_chg;
      if (thr_set) m_thr = 1;
      else if (thr_load || (id_rd && cur == 6'b000010)) m_thr = 0;
      if (rx_wr && spc_en && rx_byte == xoff2) m_spc = 1;
      else if (spc_clr) m_spc = 0;
      if ((cts_n && !m_pc) || (rts_n && !m_pr)) m_flow = 1;
      else if (flow_clr) m_flow = 0;
      m_pc = cts_n; m_pr = rts_n;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [5:0] e;
    e = m_code();
    chk(req_of(e), iid[5:0], e);
    chk("R8", iid[7:6], {fifo_en, fifo_en});
    chk("R9", irq, (e != 6'b000001));
    chk("R6", {fifo_wr, fifo_byte}, {rx_wr, rx_byte});
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic look(); @(negedge clk); endtask
  task automatic drop_pulses();
    thr_set = 0; thr_load = 0; rx_wr = 0; spc_clr = 0; flow_clr = 0; id_rd = 0;
  endtask

  initial begin
    #(5 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look(); chk("R1", iid, 8'h01); chk("R1", irq, 0);
    cyc(); fifo_en = 1; look(); chk("R8", iid, 8'hC1);
    cyc(); msr_chg = 1; look(); chk("R11", iid[5:0], 6'b000001);
    look(); chk("R5", iid[5:0], 6'b000000); chk("R1", irq, 1);
    cyc(); thr_set = 1; cyc(); drop_pulses(); look(); chk("R4", iid[5:0], 6'b000010);
    cyc(); rx_rdy = 1; cyc(); look(); chk("R3", iid[5:0], 6'b000100);
    rx_tmo = 1; cyc(); look(); chk("R3", iid[5:0], 6'b001100);
    lsr_err = 1; cyc(); look(); chk("R2", iid[5:0], 6'b000110);
    id_rd = 1; cyc(); drop_pulses();
    lsr_err = 0; rx_tmo = 0; rx_rdy = 0; cyc(); look(); chk("R10", iid[5:0], 6'b000010);
    id_rd = 1; cyc(); drop_pulses(); look(); chk("R4", iid[5:0], 6'b000000);
    id_rd = 1; cyc(); drop_pulses(); look(); chk("R10", iid[5:0], 6'b000000);
    ien = 6'b110111; look(); chk("R9", irq, 0); chk("R9", iid[0], 1);
    ien = 6'h3f; msr_chg = 0; spc_en = 1; rx_wr = 1; rx_byte = 8'h13;
    look(); chk("R6", {fifo_wr, fifo_byte}, 9'h113);
    cyc(); drop_pulses(); rx_wr = 1; rx_byte = 8'h11; cyc(); drop_pulses();
    look(); chk("R6", iid[5:0], 6'b010000);
    spc_clr = 1; spc_en = 0; rx_wr = 1; rx_byte = 8'h13; cyc(); drop_pulses(); look();
    chk("R6", iid[5:0], 6'b000001);
    cts_n = 0; cyc(); cts_n = 1; cyc(); look(); chk("R7", iid[5:0], 6'b100000);
    thr_set = 1; cyc(); drop_pulses(); look(); chk("R4", iid[5:0], 6'b000010);
    thr_load = 1; flow_clr = 1; cyc(); drop_pulses(); look(); chk("R7", iid[5:0], 6'b000001);
    rts_n = 0; cyc(); rts_n = 1; cyc(); look(); chk("R7", iid[5:0], 6'b100000);
    flow_clr = 1; cyc(); drop_pulses();
    for (int i = 0; i < 4000; i++) begin
      cyc(); drop_pulses();
      lsr_err = ($urandom % 8) == 0; rx_tmo = ($urandom % 6) == 0;
      rx_rdy = ($urandom % 4) == 0; msr_chg = ($urandom % 5) == 0;
      thr_set = ($urandom % 6) == 0; thr_load = ($urandom % 10) == 0;
      id_rd = ($urandom % 3) == 0; spc_en = ($urandom % 2) == 0;
      rx_wr = ($urandom % 3) == 0; rx_byte = ($urandom % 3) == 0 ? xoff2 : 8'($urandom);
      spc_clr = ($urandom % 12) == 0; flow_clr = ($urandom % 12) == 0;
      cts_n = ($urandom % 5) != 0; rts_n = ($urandom % 5) != 0;
      fifo_en = ($urandom % 9) != 0;
      ien = ($urandom % 4) == 0 ? 6'($urandom) : 6'h3f;
    end
    cyc(); look();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule